// File: doc/BRIEF.md
# Sine PWM Waveform Generator

This block drives a single-bit pulse-width-modulated output whose duty cycle follows a sampled sine wave. After an external RC low-pass filter, the output approximates a sinusoid. A prescaler divides the clock into ticks. A period counter counts the ticks. Each period, the output is high while the count is below a compare value.

The compare value for each period comes from an internal sine table. The table holds one full wave of samples, each already offset by half a period, so that a zero sample gives a 50% duty cycle. A step index selects the table entry. The index advances once per PWM period and wraps after the last sample. A shadow register is loaded from the table and copied into the active compare register only at the period boundary. This keeps the duty cycle fixed within a period.

The resulting sine frequency is clk / (divide ratio × PERIOD × N_SAMPLES). The integration adjusts it through the prescaler input or the two parameters.

Top module: `spwm_gen`

## Requirements
- R1: While `rst_ni` is low, and from the clock edge after `en_i` goes low, `idx_o` reads 0, `period_end_o` is low and the sample counter and divider are held at zero. `pwm_o` is low whenever `en_i` is low, including in the same cycle that `en_i` falls.
- R2: While enabled, one PWM period lasts exactly PERIOD × D clock cycles, where D is the divide ratio. `period_end_o` is high for exactly one cycle per period, and that cycle is the last cycle of the period.
- R3: In a period that plays table entry k, `pwm_o` is high for C(k) × D cycles, where C(k) = round(PERIOD/2 + (PERIOD/2)·sin(2πk/N_SAMPLES)), clamped to 0..PERIOD.
- R4: `idx_o` holds its value for a whole period. It steps by one at each period end and returns from N_SAMPLES−1 to 0.
- R5: The first period after `en_i` rises plays entry 0 (`idx_o` = 0), even when the previous run was stopped in the middle of a period.
- R6: `presc_i` = p gives D = p for p ≥ 1. A value of 0 behaves like 1.
- R7: An entry whose compare value is 0 keeps `pwm_o` low for the whole period. An entry whose value is PERIOD keeps it high for the whole period. With the defaults, these are entries 24 and 8.
- R8: The active compare value changes only at a period end, where it takes the shadow value, or when disabled, where it takes entry 0.
- R9: One full sine cycle, which is N_SAMPLES consecutive periods starting at entry 0, lasts N_SAMPLES × PERIOD × D clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds counters at zero and output low |
| presc_i | input | PRESC_W | Clock divide ratio for the period counter (0 treated as 1) |
| pwm_o | output | 1 | PWM output |
| idx_o | output | $clog2(N_SAMPLES) | Table entry played in the current period |
| period_end_o | output | 1 | High in the last cycle of each PWM period |

## Verification
Three events coincide on the edge that ends a period: the counter wrap, the step index wrap from the last sample to 0, and the copy from the shadow register into the active compare register. The bench runs more than N_SAMPLES consecutive periods at several divide ratios so that this coincidence happens. It then checks the first period after the index wrap for entry 0's exact high time and for the full period length. A mid-period disable followed by a re-enable checks that the reload path restarts cleanly at entry 0.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
  // compare value for sample k of an n-sample full wave, offset by period/2
  function automatic int sine_cmp(int k, int n, int period);
    real ph;
    real v;
    int  r;
    ph = 6.283185307179586 * real'(k) / real'(n);
    v  = (real'(period) / 2.0) * (1.0 + $sin(ph));
    r  = $rtoi(v + 0.5);
    if (r < 0) r = 0;
    if (r > period) r = period;
    return r;
  endfunction
endpackage

// File: rtl/spwm_presc.sv
`timescale 1ns/1ps
module spwm_presc #(
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] pc_q;
  logic [PRESC_W-1:0] lim;

  assign lim    = (presc_i == '0) ? '0 : presc_i - 1'b1;
  assign tick_o = en_i && (pc_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (!en_i || tick_o)   pc_q <= '0;
    else                        pc_q <= pc_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && presc_i > 1) |=> (!tick_o || presc_i <= 1)); // R6
  AST_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o); // R1
endmodule

// File: rtl/spwm_lut.sv
`timescale 1ns/1ps
module spwm_lut #(
  parameter int N_SAMPLES = 32,
  parameter int PERIOD    = 32,
  parameter int IDX_W     = $clog2(N_SAMPLES),
  parameter int CMP_W     = $clog2(PERIOD + 1)
) (
  input  logic [IDX_W-1:0] addr_i,
  output logic [CMP_W-1:0] val_o
);
  logic [CMP_W-1:0] tbl [N_SAMPLES];

  for (genvar k = 0; k < N_SAMPLES; k++) begin : g_ent
    localparam int V = spwm_pkg::sine_cmp(k, N_SAMPLES, PERIOD);
    assign tbl[k] = CMP_W'(V);
  end

  assign val_o = tbl[addr_i];
endmodule

// File: rtl/spwm_cmp.sv
`timescale 1ns/1ps
module spwm_cmp #(
  parameter int N_SAMPLES = 32,
  parameter int PERIOD    = 32,
  parameter int CMP_W     = $clog2(PERIOD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CMP_W-1:0] next_val_i,
  output logic             pwm_o,
  output logic             wrap_o
);
  localparam int              FIRST_I = spwm_pkg::sine_cmp(0, N_SAMPLES, PERIOD);
  localparam logic [CMP_W-1:0] FIRST  = CMP_W'(FIRST_I);
  localparam logic [CMP_W-1:0] LAST   = CMP_W'(PERIOD - 1);

  logic [CMP_W-1:0] cnt_q;
  logic [CMP_W-1:0] sh_q;
  logic [CMP_W-1:0] act_q;

  assign wrap_o = tick_i && (cnt_q == LAST);
  assign pwm_o  = en_i && (cnt_q < act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // shadow tracks the next sample; active copy only moves at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= FIRST;
    end else begin
      sh_q <= next_val_i;
      if (!en_i)       act_q <= FIRST;
      else if (wrap_o) act_q <= sh_q;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CMP_W'(PERIOD)); // R2
  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_o) |=> (act_q == $past(act_q))); // R8
  AST_CMP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (act_q == $past(sh_q))); // R8
  AST_CMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q <= CMP_W'(PERIOD)); // R3
endmodule

// File: rtl/spwm_gen.sv
`timescale 1ns/1ps
module spwm_gen #(
  parameter int PERIOD    = 32,
  parameter int N_SAMPLES = 32,
  parameter int PRESC_W   = 8,
  localparam int IDX_W    = $clog2(N_SAMPLES),
  localparam int CMP_W    = $clog2(PERIOD + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               pwm_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               period_end_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_SAMPLES - 1);

  logic             tick;
  logic             wrap;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] nxt_idx;
  logic [CMP_W-1:0] nxt_val;

  assign nxt_idx = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (!en_i)  idx_q <= '0;
    else if (wrap)   idx_q <= nxt_idx;
  end

  spwm_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .presc_i(presc_i),
    .tick_o (tick)
  );

  spwm_lut #(.N_SAMPLES(N_SAMPLES), .PERIOD(PERIOD), .IDX_W(IDX_W), .CMP_W(CMP_W)) u_lut (
    .addr_i(nxt_idx),
    .val_o (nxt_val)
  );

  spwm_cmp #(.N_SAMPLES(N_SAMPLES), .PERIOD(PERIOD), .CMP_W(CMP_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .next_val_i(nxt_val),
    .pwm_o     (pwm_o),
    .wrap_o    (wrap)
  );

  assign idx_o        = idx_q;
  assign period_end_o = wrap;

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (idx_q == (($past(idx_q) == IDX_LAST) ? '0 : $past(idx_q) + 1'b1))); // R4
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap) |=> $stable(idx_q)); // R4
  AST_DIS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (idx_q == '0)); // R1
  AST_PWM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!pwm_o && !period_end_o)); // R1
endmodule

// File: tb/sim_spwm_gen.sv
`timescale 1ns/1ps
module sim_spwm_gen;
  localparam int PERIOD = 32;
  localparam int NS     = 32;
  localparam int PW     = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic [PW-1:0] presc_i = '0;
  logic          pwm_o;
  logic [4:0]    idx_o;
  logic          period_end_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spwm_gen #(.PERIOD(PERIOD), .N_SAMPLES(NS), .PRESC_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .presc_i(presc_i),
    .pwm_o(pwm_o), .idx_o(idx_o), .period_end_o(period_end_o)
  );

  function automatic int exp_cmp(int k);
    real s;
    int  r;
    s = $sin(2.0 * 3.141592653589793 * real'(k) / real'(NS));
    r = $rtoi(real'(PERIOD) / 2.0 + real'(PERIOD) / 2.0 * s + 0.5);
    if (r < 0) r = 0;
    if (r > PERIOD) r = PERIOD;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int pset, input int nper);
    int dv;
    int total;
    dv = (pset == 0) ? 1 : pset;
    total = 0;
    @(negedge clk);
    presc_i = PW'(pset);
    en_i = 1'b1;
    for (int p = 0; p < nper; p++) begin
      int hi, len, id0, ex, moved;
      hi = 0; len = 0; id0 = -1; moved = 0;
      while (len < PERIOD * dv + 4) begin
        #1;
        len++;
        if (pwm_o) hi++;
        if (id0 < 0) id0 = int'(idx_o);
        else if (int'(idx_o) != id0) moved++;
        if (period_end_o) break;
        @(negedge clk);
      end
      total += len;
      ex = exp_cmp(p % NS);
      chk(len == PERIOD * dv, "R2 period length", len, PERIOD * dv);
      chk(id0 == p % NS && moved == 0, "R4 index per period", id0, p % NS);
      if (p == 0) chk(id0 == 0, "R5 first entry", id0, 0);
      chk(hi == ex * dv, "R3 high time", hi, ex * dv);
      if (dv != 1) chk(len == PERIOD * int'(presc_i), "R6 divide ratio", len, PERIOD * int'(presc_i));
      else chk(len == PERIOD, "R6 unit divide", len, PERIOD);
      if (ex == 0) chk(hi == 0, "R7 zero duty", hi, 0);
      if (ex == PERIOD) chk(hi == len, "R7 full duty", hi, len);
      if (p == NS - 1) chk(total == NS * PERIOD * dv, "R9 sine cycle length", total, NS * PERIOD * dv);
      @(negedge clk);
    end
  endtask

  task automatic stop_run();
    en_i = 1'b0;
    #1;
    chk(pwm_o == 1'b0, "R1 output low on disable", int'(pwm_o), 0);
    @(negedge clk);
    #1;
    chk(idx_o == '0, "R1 index cleared", int'(idx_o), 0);
    chk(period_end_o == 1'b0, "R1 no strobe while idle", int'(period_end_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pwm_o == 1'b0 && idx_o == '0 && period_end_o == 1'b0, "R1 reset state",
        int'({pwm_o, idx_o, period_end_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(pwm_o == 1'b0 && idx_o == '0, "R1 idle after reset", int'({pwm_o, idx_o}), 0);

    run(1, NS + 3);          // index wraps at the same edge as a period end
    stop_run();
    run(3, 12);
    stop_run();
    run(0, 4);               // R6 zero behaves as one
    stop_run();

    // mid-period disable then restart at entry 0
    @(negedge clk);
    presc_i = PW'(2);
    en_i = 1'b1;
    repeat (PERIOD * 2 * 3 + 11) @(negedge clk);
    stop_run();
    run(2, NS + 1);
    stop_run();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule